// File: doc/BRIEF.md
# Operand Bypass Selector for a Five-Stage Pipeline

This block sits beside the decode stage of a pipeline that runs fetch, decode, execute, buffer and write-back. Decode reads up to three source registers at once. For each of them the block checks whether an older instruction is still carrying a result for that register in one of the three later stages. If one is, the block routes that in-flight result to the operand in place of the stale register-file value. The register file, the ALU and the data memory are outside the block. Their values arrive as inputs, and the block returns one selected value per operand.

When several later stages hold a result for the same register, the youngest one wins. A load that is still in the execute stage has no data yet, because memory data exists only once the buffer stage finishes. A consumer of that load cannot be served in this cycle, so the block raises a stall request. The program counter register is never bypassed; reads of it return the program counter input.

The logic is purely combinational from inputs to outputs. The clock and reset inputs serve only the embedded property checks.

Top module: `fwd_unit`

## Requirements
- R1: An operand with no qualifying match in any later stage gets select code 0 and the value from its register-file port.
- R2: An operand whose register matches a non-load result in the execute stage gets select code 1 and the execute result.
- R3: An operand matching only the buffer stage gets select code 2 and the buffer result. One matching only the write-back stage gets select code 3 and the write-back result.
- R4: When more than one stage matches, the youngest producer wins, in the order execute, then buffer, then write-back.
- R5: A stage counts as a match only when both its valid bit and its write-enable are high.
- R6: If an operand matches a load in the execute stage, stall is high and the execute result is not chosen. The operand falls back to the next older match, or to the register file if there is none.
- R7: Register 15 always gets select code 0 and the program counter input. It never causes a stall, whatever the later stages hold.
- R8: The three operands are resolved independently of one another, each through its own 2-bit select and 32-bit value.
- R9: Stall is low whenever no operand (other than register 15) matches a load in the execute stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the embedded checks |
| rst_n | input | 1 | Active-low reset for the embedded checks |
| src_idx | input | 12 | Three 4-bit source register numbers; operand k is in bits [4k+3:4k] |
| rf_data | input | 96 | Three register-file read values; operand k is in bits [32k+31:32k] |
| pc_value | input | 32 | Value returned for register 15 |
| ex_valid | input | 1 | Execute stage holds a live instruction |
| ex_wen | input | 1 | Execute-stage instruction writes a register |
| ex_load | input | 1 | Execute-stage instruction is a load |
| ex_dst | input | 4 | Execute-stage destination register |
| ex_result | input | 32 | Execute-stage result |
| bf_valid | input | 1 | Buffer stage holds a live instruction |
| bf_wen | input | 1 | Buffer-stage instruction writes a register |
| bf_dst | input | 4 | Buffer-stage destination register |
| bf_result | input | 32 | Buffer-stage result (ALU value or loaded data) |
| wb_valid | input | 1 | Write-back stage holds a live instruction |
| wb_wen | input | 1 | Write-back instruction writes a register |
| wb_dst | input | 4 | Write-back destination register |
| wb_result | input | 32 | Write-back result |
| op_sel | output | 6 | Three 2-bit select codes (0 file, 1 execute, 2 buffer, 3 write-back); operand k is in bits [2k+1:2k] |
| op_data | output | 96 | Three selected operand values |
| stall | output | 1 | Load-use stall request |

## Verification
The bench aims the same register at all three later stages at once. An inverted priority chain would then return an older result and the wrong select code. It toggles valid and write-enable separately on matching stages; a design that checks only one of them would forward from a bubble or from a non-writing instruction. It places a load in execute with an older match behind it. A design that forwards the load's execute value or skips the fall-back gets the value wrong, and one that misses the stall lets the consumer read garbage. Register 15 is aimed at every stage, including a load, to catch a design that bypasses the program counter or stalls on it.

// File: rtl/fwd_unit.sv
module fwd_unit #(
  parameter int DW     = 32,
  parameter int RW     = 4,
  parameter int NSRC   = 3,
  parameter int PC_REG = 15
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NSRC*RW-1:0]   src_idx,
  input  logic [NSRC*DW-1:0]   rf_data,
  input  logic [DW-1:0]        pc_value,
  input  logic                 ex_valid,
  input  logic                 ex_wen,
  input  logic                 ex_load,
  input  logic [RW-1:0]        ex_dst,
  input  logic [DW-1:0]        ex_result,
  input  logic                 bf_valid,
  input  logic                 bf_wen,
  input  logic [RW-1:0]        bf_dst,
  input  logic [DW-1:0]        bf_result,
  input  logic                 wb_valid,
  input  logic                 wb_wen,
  input  logic [RW-1:0]        wb_dst,
  input  logic [DW-1:0]        wb_result,
  output logic [NSRC*2-1:0]    op_sel,
  output logic [NSRC*DW-1:0]   op_data,
  output logic                 stall
);

  localparam logic [1:0] SEL_RF = 2'd0;
  localparam logic [1:0] SEL_EX = 2'd1;
  localparam logic [1:0] SEL_BF = 2'd2;
  localparam logic [1:0] SEL_WB = 2'd3;
  localparam logic [RW-1:0] PCR = RW'(PC_REG);

  wire ex_live = ex_valid & ex_wen;
  wire bf_live = bf_valid & bf_wen;
  wire wb_live = wb_valid & wb_wen;

  logic [NSRC-1:0] load_use;

  for (genvar k = 0; k < NSRC; k++) begin : g_op
    wire [RW-1:0] s      = src_idx[k*RW +: RW];
    wire [DW-1:0] rf     = rf_data[k*DW +: DW];
    wire          is_pc  = (s == PCR);
    wire          hit_ex = ex_live & (ex_dst == s) & ~is_pc;
    wire          hit_bf = bf_live & (bf_dst == s) & ~is_pc;
    wire          hit_wb = wb_live & (wb_dst == s) & ~is_pc;
    logic [1:0]   sel;
    logic [DW-1:0] val;

    assign load_use[k] = hit_ex & ex_load;

    always_comb begin
      if (hit_ex && !ex_load) sel = SEL_EX;
      else if (hit_bf)        sel = SEL_BF;
      else if (hit_wb)        sel = SEL_WB;
      else                    sel = SEL_RF;
    end

    always_comb begin
      case (sel)
        SEL_EX:  val = ex_result;
        SEL_BF:  val = bf_result;
        SEL_WB:  val = wb_result;
        default: val = is_pc ? pc_value : rf;
      endcase
    end

    assign op_sel[k*2 +: 2]   = sel;
    assign op_data[k*DW +: DW] = val;

    // R2: an execute pick needs a live non-load producer of this register
    a_r2_ex_source: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == SEL_EX) |-> (ex_valid && ex_wen && !ex_load && ex_dst == s && val == ex_result));

    // R4: a write-back pick means no younger stage could supply the register
    a_r4_wb_oldest: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == SEL_WB) |-> !(bf_valid && bf_wen && bf_dst == s) &&
                          !(ex_valid && ex_wen && !ex_load && ex_dst == s));

    // R5: a buffer pick only from a valid, writing stage
    a_r5_bf_qualified: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == SEL_BF) |-> (bf_valid && bf_wen && bf_dst == s && val == bf_result));

    // R7: the program counter register is never bypassed
    a_r7_pc_direct: assert property (@(posedge clk) disable iff (!rst_n)
      (s == PCR) |-> (sel == SEL_RF && val == pc_value && !load_use[k]));

    // R1: a file pick on an ordinary register returns its port value
    a_r1_rf_path: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == SEL_RF && s != PCR) |-> (val == rf));
  end

  assign stall = |load_use;

  // R6: a stall request needs a load in execute
  a_r6_stall_cause: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (ex_valid && ex_wen && ex_load));

  // R9: no load in execute means no stall
  a_r9_no_false_stall: assert property (@(posedge clk) disable iff (!rst_n)
    !(ex_valid && ex_wen && ex_load) |-> !stall);

endmodule

// File: tb/fwd_unit_bench.sv
module fwd_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] src_idx = '0;
  logic [95:0] rf_data = '0;
  logic [31:0] pc_value = '0;
  logic        ex_valid = 0, ex_wen = 0, ex_load = 0;
  logic [3:0]  ex_dst = '0;
  logic [31:0] ex_result = '0;
  logic        bf_valid = 0, bf_wen = 0;
  logic [3:0]  bf_dst = '0;
  logic [31:0] bf_result = '0;
  logic        wb_valid = 0, wb_wen = 0;
  logic [3:0]  wb_dst = '0;
  logic [31:0] wb_result = '0;
  logic [5:0]  op_sel;
  logic [95:0] op_data;
  logic        stall;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  fwd_unit u_fwd_unit (
    .clk(clk), .rst_n(rst_n), .src_idx(src_idx), .rf_data(rf_data), .pc_value(pc_value),
    .ex_valid(ex_valid), .ex_wen(ex_wen), .ex_load(ex_load), .ex_dst(ex_dst), .ex_result(ex_result),
    .bf_valid(bf_valid), .bf_wen(bf_wen), .bf_dst(bf_dst), .bf_result(bf_result),
    .wb_valid(wb_valid), .wb_wen(wb_wen), .wb_dst(wb_dst), .wb_result(wb_result),
    .op_sel(op_sel), .op_data(op_data), .stall(stall)
  );

  function automatic logic [1:0] exp_sel(input logic [3:0] s);
    if (s == 4'd15) return 2'd0;
    if (ex_valid && ex_wen && ex_dst == s && !ex_load) return 2'd1;
    if (bf_valid && bf_wen && bf_dst == s) return 2'd2;
    if (wb_valid && wb_wen && wb_dst == s) return 2'd3;
    return 2'd0;
  endfunction

  function automatic logic [31:0] exp_val(input int k);
    logic [3:0] s = src_idx[k*4 +: 4];
    case (exp_sel(s))
      2'd1: return ex_result;
      2'd2: return bf_result;
      2'd3: return wb_result;
      default: return (s == 4'd15) ? pc_value : rf_data[k*32 +: 32];
    endcase
  endfunction

  function automatic logic exp_stall();
    for (int k = 0; k < 3; k++) begin
      logic [3:0] s = src_idx[k*4 +: 4];
      if (s != 4'd15 && ex_valid && ex_wen && ex_load && ex_dst == s) return 1'b1;
    end
    return 1'b0;
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0h expected=%0h", tag, got, exp);
    end
  endtask

  task automatic check_all(input string tag);
    #1;
    for (int k = 0; k < 3; k++) begin
      chk($sformatf("%s op%0d sel", tag, k), 32'(op_sel[k*2 +: 2]), 32'(exp_sel(src_idx[k*4 +: 4])));
      chk($sformatf("%s op%0d data", tag, k), op_data[k*32 +: 32], exp_val(k));
    end
    chk($sformatf("%s stall", tag), 32'(stall), 32'(exp_stall()));
  endtask

  task automatic set_values();
    rf_data   = {32'hA2A2_0002, 32'hA1A1_0001, 32'hA0A0_0000};
    pc_value  = 32'hC0DE_0008;
    ex_result = 32'hEEEE_1111;
    bf_result = 32'hBBBB_2222;
    wb_result = 32'hDDDD_3333;
  endtask

  task automatic stages(input logic ev, ew, el, input logic [3:0] ed,
                        input logic bv, bw, input logic [3:0] bd,
                        input logic wv, ww, input logic [3:0] wd);
    ex_valid = ev; ex_wen = ew; ex_load = el; ex_dst = ed;
    bf_valid = bv; bf_wen = bw; bf_dst = bd;
    wb_valid = wv; wb_wen = ww; wb_dst = wd;
  endtask

  function automatic logic [3:0] pick_reg();
    logic [31:0] r = $urandom;
    if (r[0]) return 4'(r[5:1] % 4 == 3 ? 15 : r[5:1] % 4 + 1);
    return r[11:8];
  endfunction

  initial begin
    void'($urandom(32'd20240611));
    set_values();
    src_idx = {4'd3, 4'd2, 4'd1};
    @(negedge clk);
    check_all("R1 reset");
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: no producers
    stages(0,0,0,4'd1, 0,0,4'd2, 0,0,4'd3);
    check_all("R1 idle");
    @(negedge clk);
    // R2: execute hit on op0
    stages(1,1,0,4'd1, 0,0,4'd0, 0,0,4'd0);
    check_all("R2 ex");
    @(negedge clk);
    // R3: buffer hit op1, write-back hit op2
    stages(0,0,0,4'd0, 1,1,4'd2, 1,1,4'd3);
    check_all("R3 bf wb");
    @(negedge clk);
    // R4: all three stages target register 1
    src_idx = {4'd1, 4'd1, 4'd1};
    stages(1,1,0,4'd1, 1,1,4'd1, 1,1,4'd1);
    check_all("R4 all ex");
    @(negedge clk);
    stages(0,1,0,4'd1, 1,1,4'd1, 1,1,4'd1);
    check_all("R4 bf over wb");
    @(negedge clk);
    // R5: valid without write-enable, and write-enable without valid
    stages(1,0,0,4'd1, 0,1,4'd1, 1,1,4'd1);
    check_all("R5 qualify");
    @(negedge clk);
    stages(1,0,0,4'd1, 0,1,4'd1, 1,0,4'd1);
    check_all("R5 none");
    @(negedge clk);
    // R6: load in execute, fallback to buffer, then to file
    src_idx = {4'd3, 4'd2, 4'd1};
    stages(1,1,1,4'd2, 1,1,4'd2, 0,0,4'd0);
    check_all("R6 load fallback");
    @(negedge clk);
    stages(1,1,1,4'd3, 0,0,4'd0, 0,0,4'd0);
    check_all("R6 load rf");
    @(negedge clk);
    // R7: register 15 targeted everywhere, including a load
    src_idx = {4'd15, 4'd15, 4'd15};
    stages(1,1,1,4'd15, 1,1,4'd15, 1,1,4'd15);
    check_all("R7 pc");
    @(negedge clk);
    // R9: non-writing load matches but no stall
    src_idx = {4'd3, 4'd2, 4'd1};
    stages(1,0,1,4'd1, 0,0,4'd0, 0,0,4'd0);
    check_all("R9 no stall");
    @(negedge clk);
    // R8: random mixes, each operand independent
    for (int i = 0; i < 3000; i++) begin
      src_idx   = {pick_reg(), pick_reg(), pick_reg()};
      rf_data   = {$urandom, $urandom, $urandom};
      pc_value  = $urandom;
      ex_result = $urandom; bf_result = $urandom; wb_result = $urandom;
      stages(1'($urandom), 1'($urandom), 1'($urandom), pick_reg(),
             1'($urandom), 1'($urandom), pick_reg(),
             1'($urandom), 1'($urandom), pick_reg());
      check_all("R8 random");
      @(negedge clk);
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired got=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule